// File: doc/BRIEF.md
# Wide Register Indirect Access Bridge

This block sits as a slave on a 32-bit register bus and opens a window onto a space of 64-bit registers that the bus cannot reach directly. Software places a 64-bit value in two 32-bit staging windows. It then writes one command word that holds an inner register address and a direction flag. That single write starts a complete 64-bit read or write on an inner request/acknowledge port.

A read returns the inner value into the same two windows, where software picks it up as two halves. Two kinds of failure are latched in a sticky status word: an inner acknowledge flagged as an error, and a request that gets no acknowledge within a fixed timeout. A write to a dedicated clear register releases them. An enable register gates an interrupt line from the summary error flag.

Top module: `wreg_bridge`

## Requirements
- R1: After reset, both data windows, the command register, the status word and the interrupt enable read as zero, in_req is low and irq is low.
- R2: The window at byte offset 0x00 holds bits 63:32 of the staged value and the window at 0x04 holds bits 31:0. Both are writable from the bus. Reading them returns the last written or captured value and starts no inner access.
- R3: Writing the command register at 0x08 with bit 31 set issues exactly one inner write on the next cycle. The inner write carries in_we=1, in_addr equal to command bits IADDR_W-1:0, and in_wdata equal to {window 0x00, window 0x04}. Loading the windows alone issues no inner access.
- R4: Writing the command register with bit 31 clear issues an inner read (in_we=0). When an acknowledge arrives without error, in_rdata[63:32] is loaded into window 0x00 and in_rdata[31:0] into window 0x04.
- R5: Status at 0x1C bit 0 (busy) is set from the cycle after a command is accepted until the cycle after the acknowledge or the timeout. While in_req waits, in_addr and in_we hold steady.
- R6: While busy, writes to the command register and to both data windows are ignored.
- R7: An acknowledge with in_err high sets status bit 2 and the summary bit 31, and the windows keep their previous value.
- R8: A request with no acknowledge for TIMEOUT cycles is withdrawn. This clears busy and sets status bit 1 and bit 31.
- R9: Error bits stay set until any bus write to the clear register at 0x18, which zeroes them. A new error in the same cycle as a clear is kept.
- R10: Bit 0 of the interrupt register at 0x20 is an enable, and irq equals that enable AND status bit 31.
- R11: The clear register and any offset not named here read as zero. Bus writes to unnamed offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| in_req | output | 1 | Inner access request, held until acknowledge or timeout |
| in_we | output | 1 | Inner access direction, 1 = write |
| in_addr | output | IADDR_W | Inner register address |
| in_wdata | output | 64 | Inner write value |
| in_ack | input | 1 | Inner acknowledge |
| in_err | input | 1 | Inner acknowledge carries an error (unmapped address) |
| in_rdata | input | 64 | Inner read value, valid with in_ack |
| irq | output | 1 | Error interrupt |

## Verification
A wrong sequencer state shows at the ports within one cycle of a command write. The symptoms are a missing or doubled in_req pulse, an address that differs from the command word, or a busy bit that never falls. A capture fault shows as a wrong half in the window readback right after the read completes. Writing each mapped inner register and reading it back over several acknowledge latencies exposes swapped halves, address truncation and lost data. A stuck or missing error latch shows in the status word on the first failed access, and also after the clear write.

// File: rtl/wreg_bridge_pkg.sv
// Package: offsets, status bit positions and the decode type shared by the
// bridge modules. Offsets are byte addresses on the 32-bit bus.
package wreg_bridge_pkg;
    localparam int BUS_AW = 6;

    localparam logic [BUS_AW-1:0] OFS_WIN_HI = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_WIN_LO = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_CMD    = 6'h08;
    localparam logic [BUS_AW-1:0] OFS_CLEAR  = 6'h18;
    localparam logic [BUS_AW-1:0] OFS_STAT   = 6'h1C;
    localparam logic [BUS_AW-1:0] OFS_IRQ    = 6'h20;

    localparam int ST_BUSY = 0;
    localparam int ST_TMO  = 1;
    localparam int ST_NACK = 2;
    localparam int ST_ANY  = 31;
    localparam int CMD_DIR = 31;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_WIN_HI, SEL_WIN_LO, SEL_CMD, SEL_CLEAR, SEL_STAT, SEL_IRQ
    } reg_sel_e;

    // Map a bus byte offset onto one register of the bridge.
    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] a);
        case (a)
            OFS_WIN_HI: return SEL_WIN_HI;
            OFS_WIN_LO: return SEL_WIN_LO;
            OFS_CMD:    return SEL_CMD;
            OFS_CLEAR:  return SEL_CLEAR;
            OFS_STAT:   return SEL_STAT;
            OFS_IRQ:    return SEL_IRQ;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/wreg_bridge_regs.sv
// Bus-side register file: decodes offsets, holds the two data windows, the
// last command word and the interrupt enable, and builds the read data.
// Assumes bus accesses last one cycle and reads are combinational.
module wreg_bridge_regs
    import wreg_bridge_pkg::*;
#(
    parameter int IADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               busy,
    input  logic               cap_valid,
    input  logic [63:0]        cap_data,
    input  logic               err_tmo,
    input  logic               err_nack,
    input  logic               err_any,
    output logic [63:0]        staged,
    output logic               cmd_start,
    output logic               cmd_we,
    output logic [IADDR_W-1:0] cmd_addr,
    output logic               clr_err,
    output logic               irq_en
);
    reg_sel_e    sel;
    logic        wr_hit;
    logic [31:0] win_hi;
    logic [31:0] win_lo;
    logic [31:0] cmd_q;
    logic [31:0] stat_word;

    // Decode the current bus offset.
    always_comb sel = decode_ofs(bus_addr);

    assign wr_hit    = bus_sel && bus_wr;
    assign cmd_start = wr_hit && (sel == SEL_CMD) && !busy;
    assign cmd_we    = bus_wdata[CMD_DIR];
    assign cmd_addr  = bus_wdata[IADDR_W-1:0];
    assign clr_err   = wr_hit && (sel == SEL_CLEAR);
    assign staged    = {win_hi, win_lo};

    // Data windows: bus writes when idle, inner read capture otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_hi <= '0;
            win_lo <= '0;
        end else if (cap_valid) begin
            win_hi <= cap_data[63:32];
            win_lo <= cap_data[31:0];
        end else if (wr_hit && !busy) begin
            if (sel == SEL_WIN_HI) win_hi <= bus_wdata;
            if (sel == SEL_WIN_LO) win_lo <= bus_wdata;
        end
    end

    // Command word copy for readback, accepted only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cmd_q <= '0;
        else if (cmd_start)  cmd_q <= bus_wdata;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq_en <= 1'b0;
        else if (wr_hit && sel == SEL_IRQ)   irq_en <= bus_wdata[0];
    end

    // Status word assembly.
    always_comb begin
        stat_word          = '0;
        stat_word[ST_BUSY] = busy;
        stat_word[ST_TMO]  = err_tmo;
        stat_word[ST_NACK] = err_nack;
        stat_word[ST_ANY]  = err_any;
    end

    // Read data multiplexer.
    always_comb begin
        case (sel)
            SEL_WIN_HI: bus_rdata = win_hi;
            SEL_WIN_LO: bus_rdata = win_lo;
            SEL_CMD:    bus_rdata = cmd_q;
            SEL_STAT:   bus_rdata = stat_word;
            SEL_IRQ:    bus_rdata = {31'b0, irq_en};
            default:    bus_rdata = '0;
        endcase
    end

    // Windows do not move while an access is in flight, except by capture.
    p_win_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cap_valid |=> $stable(win_hi) && $stable(win_lo));

    // A capture lands both halves in the windows.
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> staged == $past(cap_data));
endmodule

// File: rtl/wreg_bridge_seq.sv
// Inner access sequencer: latches a started command, holds the request until
// acknowledge or timeout, and reports capture, error and timeout events.
// Assumes the inner side acknowledges for at most one cycle per request.
module wreg_bridge_seq #(
    parameter int IADDR_W = 8,
    parameter int TIMEOUT = 16,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_we,
    input  logic [IADDR_W-1:0] start_addr,
    output logic               req,
    output logic               req_we,
    output logic [IADDR_W-1:0] req_addr,
    input  logic               ack,
    input  logic               ack_err,
    input  logic [63:0]        rdata,
    output logic               cap_valid,
    output logic [63:0]        cap_data,
    output logic               nack_evt,
    output logic               tmo_evt
);
    logic [CW-1:0] wait_cnt;
    logic          done;

    assign tmo_evt   = req && !ack && (wait_cnt == CW'(TIMEOUT - 1));
    assign done      = req && (ack || tmo_evt);
    assign cap_valid = req && ack && !ack_err && !req_we;
    assign cap_data  = rdata;
    assign nack_evt  = req && ack && ack_err;

    // Request register, latched command and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= 1'b0;
            req_we   <= 1'b0;
            req_addr <= '0;
            wait_cnt <= '0;
        end else if (done) begin
            req      <= 1'b0;
            wait_cnt <= '0;
        end else if (req) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else if (start) begin
            req      <= 1'b1;
            req_we   <= start_we;
            req_addr <= start_addr;
            wait_cnt <= '0;
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack && !tmo_evt |=> req && $stable(req_addr) && $stable(req_we));

    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack |=> !req);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req && start |=> req && req_addr == $past(start_addr) && req_we == $past(start_we));

    p_tmo_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> !req);
endmodule

// File: rtl/wreg_bridge_err.sv
// Sticky error capture: timeout and error-acknowledge flags, cleared by a
// write to the clear register; a new error in the clearing cycle is kept.
module wreg_bridge_err (
    input  logic clk,
    input  logic rst_n,
    input  logic nack_evt,
    input  logic tmo_evt,
    input  logic clr,
    output logic err_nack,
    output logic err_tmo,
    output logic err_any
);
    // Sticky flag update, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_nack <= 1'b0;
            err_tmo  <= 1'b0;
        end else begin
            err_nack <= nack_evt || (err_nack && !clr);
            err_tmo  <= tmo_evt  || (err_tmo  && !clr);
        end
    end

    assign err_any = err_nack || err_tmo;

    p_nack_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_nack && !clr |=> err_nack);

    p_tmo_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> err_tmo);

    p_nack_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nack_evt |=> err_nack);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !nack_evt && !tmo_evt |=> !err_any);
endmodule

// File: rtl/wreg_bridge.sv
// Top of the wide-register bridge: ties the bus register file, the inner
// sequencer and the error capture together and drives the interrupt.
module wreg_bridge #(
    parameter int IADDR_W = 8,
    parameter int TIMEOUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [5:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               in_req,
    output logic               in_we,
    output logic [IADDR_W-1:0] in_addr,
    output logic [63:0]        in_wdata,
    input  logic               in_ack,
    input  logic               in_err,
    input  logic [63:0]        in_rdata,
    output logic               irq
);
    logic               cap_valid;
    logic [63:0]        cap_data;
    logic               err_tmo;
    logic               err_nack;
    logic               err_any;
    logic               cmd_start;
    logic               cmd_we;
    logic [IADDR_W-1:0] cmd_addr;
    logic               clr_err;
    logic               irq_en;
    logic               nack_evt;
    logic               tmo_evt;

    wreg_bridge_regs #(.IADDR_W(IADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(in_req), .cap_valid(cap_valid), .cap_data(cap_data),
        .err_tmo(err_tmo), .err_nack(err_nack), .err_any(err_any),
        .staged(in_wdata), .cmd_start(cmd_start), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .clr_err(clr_err), .irq_en(irq_en)
    );

    wreg_bridge_seq #(.IADDR_W(IADDR_W), .TIMEOUT(TIMEOUT)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(cmd_start), .start_we(cmd_we), .start_addr(cmd_addr),
        .req(in_req), .req_we(in_we), .req_addr(in_addr),
        .ack(in_ack), .ack_err(in_err), .rdata(in_rdata),
        .cap_valid(cap_valid), .cap_data(cap_data),
        .nack_evt(nack_evt), .tmo_evt(tmo_evt)
    );

    wreg_bridge_err u_err (
        .clk(clk), .rst_n(rst_n),
        .nack_evt(nack_evt), .tmo_evt(tmo_evt), .clr(clr_err),
        .err_nack(err_nack), .err_tmo(err_tmo), .err_any(err_any)
    );

    assign irq = irq_en && err_any;

    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> err_any);

    p_wdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && !in_ack |=> $stable(in_wdata) || !in_req);
endmodule

// File: tb/sim_wreg_bridge.sv
`timescale 1ns/1ps
module sim_wreg_bridge;
    localparam int IADDR_W = 8;
    localparam int TIMEOUT = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [5:0]         bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               in_req;
    logic               in_we;
    logic [IADDR_W-1:0] in_addr;
    logic [63:0]        in_wdata;
    logic               in_ack = 1'b0;
    logic               in_err = 1'b0;
    logic [63:0]        in_rdata = '0;
    logic               irq;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    bit done     = 1'b0;
    logic [63:0] mem [16];

    wreg_bridge #(.IADDR_W(IADDR_W), .TIMEOUT(TIMEOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_req(in_req), .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
        .in_ack(in_ack), .in_err(in_err), .in_rdata(in_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    // Inner register model: 0..15 mapped, 16..31 answer with error, rest silent.
    initial begin
        int waited;
        waited = 0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (in_ack) begin
                in_ack = 1'b0;
                in_err = 1'b0;
                waited = 0;
            end else if (in_req) begin
                if (waited >= lat && in_addr < 32) begin
                    in_ack = 1'b1;
                    if (in_addr < 16) begin
                        in_err   = 1'b0;
                        in_rdata = mem[in_addr[3:0]];
                        if (in_we) mem[in_addr[3:0]] = in_wdata;
                    end else begin
                        in_err   = 1'b1;
                        in_rdata = 64'hDEAD_DEAD_DEAD_DEAD;
                    end
                end
                waited++;
            end else begin
                waited = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 100; i++) begin
            brd(6'h1C, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    function automatic logic [63:0] pat(input int a, input int l);
        return {32'h1000_0000 * (a + 1) + 32'(l), 32'h0F0F_0000 ^ 32'(a * 257 + l * 4099)};
    endfunction

    initial begin
        logic [31:0] r, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        brd(6'h00, r); chk("R1 win_hi", 64'(r), 0);
        brd(6'h04, r); chk("R1 win_lo", 64'(r), 0);
        brd(6'h08, r); chk("R1 cmd", 64'(r), 0);
        brd(6'h1C, r); chk("R1 status", 64'(r), 0);
        brd(6'h20, r); chk("R1 irq_en", 64'(r), 0);
        chk("R1 in_req", 64'(in_req), 0);
        chk("R1 irq", 64'(irq), 0);
        // R11: unnamed offsets and clear register read zero, writes ignored
        bwr(6'h0C, 32'hFFFF_FFFF);
        brd(6'h0C, r); chk("R11 unnamed", 64'(r), 0);
        brd(6'h18, r); chk("R11 clear reads 0", 64'(r), 0);
        brd(6'h1C, r); chk("R11 status untouched", 64'(r), 0);
        // R2/R3: windows staged, no access before the command
        bwr(6'h00, 32'hCAFE_0001);
        bwr(6'h04, 32'hBEEF_0002);
        chk("R3 no req before cmd", 64'(in_req), 0);
        brd(6'h00, r); brd(6'h00, r2);
        chk("R2 hi readback", 64'(r), 64'hCAFE_0001);
        chk("R2 read no side effect", 64'(r2), 64'(r));
        chk("R2 no req after read", 64'(in_req), 0);
        brd(6'h04, r); chk("R2 lo readback", 64'(r), 64'hBEEF_0002);
        // R3/R4: sweep every mapped inner register over several latencies
        for (int l = 0; l < 4; l++) begin
            lat = l;
            for (int a = 0; a < 16; a++) begin
                logic [63:0] v;
                v = pat(a, l);
                bwr(6'h00, v[63:32]);
                bwr(6'h04, v[31:0]);
                bwr(6'h08, 32'h8000_0000 | 32'(a));
                chk("R5 busy after cmd", 64'(in_req), 1);
                wait_idle();
                chk("R3 inner write landed", mem[a], v);
            end
            for (int a = 0; a < 16; a++) begin
                bwr(6'h08, 32'(a));
                wait_idle();
                brd(6'h00, r); chk("R4 read hi", 64'(r), 64'(pat(a, l) >> 32));
                brd(6'h04, r); chk("R4 read lo", 64'(r), 64'(pat(a, l) & 64'hFFFF_FFFF));
                brd(6'h1C, r); chk("R5 status idle", 64'(r), 0);
            end
        end
        brd(6'h08, r); chk("R2 cmd readback", 64'(r), 64'd15);
        // R7: error acknowledge, windows unchanged
        lat = 1;
        brd(6'h00, r2);
        bwr(6'h08, 32'd20);
        wait_idle();
        brd(6'h1C, r); chk("R7 nack status", 64'(r), 64'h8000_0004);
        brd(6'h00, r); chk("R7 window kept", 64'(r), 64'(r2));
        // R10: interrupt enable
        chk("R10 irq disabled", 64'(irq), 0);
        bwr(6'h20, 32'h1);
        #1 chk("R10 irq enabled", 64'(irq), 1);
        brd(6'h20, r); chk("R10 enable readback", 64'(r), 1);
        // R9: sticky until clear
        bwr(6'h0C, 32'h0);
        brd(6'h1C, r); chk("R9 still set", 64'(r), 64'h8000_0004);
        bwr(6'h18, 32'h0);
        brd(6'h1C, r); chk("R9 cleared", 64'(r), 0);
        chk("R10 irq follows", 64'(irq), 0);
        // R8 and R6: timeout, with commands and window writes during busy
        brd(6'h00, r2);
        bwr(6'h08, 32'h0000_0080);
        bwr(6'h00, 32'h1234_5678);
        bwr(6'h08, 32'h8000_0005);
        brd(6'h00, r); chk("R6 window write ignored", 64'(r), 64'(r2));
        brd(6'h08, r); chk("R6 cmd ignored", 64'(r), 64'h80);
        brd(6'h1C, r); chk("R5 busy bit", 64'(r[0]), 1);
        chk("R5 addr held", 64'(in_addr), 64'h80);
        wait_idle();
        brd(6'h1C, r); chk("R8 timeout status", 64'(r), 64'h8000_0002);
        chk("R8 req dropped", 64'(in_req), 0);
        chk("R6 mem untouched", mem[5], pat(5, 3));
        chk("R10 irq on timeout", 64'(irq), 1);
        bwr(6'h18, 32'h5);
        brd(6'h1C, r); chk("R9 timeout cleared", 64'(r), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule